// File: doc/BRIEF.md
# Clocked Video to Packet Stream Bridge

This block takes video that runs on its own clock and has no way to be stalled, and turns it into a valid/ready packet stream. It frames each video frame as one packet. A rising edge on the vertical sync input opens a frame. Pixels are captured while the data-enable input is high. The first pixel of a frame carries a start-of-packet marker and the last one carries an end-of-packet marker. A FIFO holds the captured pixels, so a downstream consumer can stall for a while, provided its average rate keeps up with the pixel rate.

When the downstream falls too far behind and storage runs out, the block closes the current packet at once. The pixel already captured becomes the packet's last item. The block then discards all input until the next frame or field start, and after that it resynchronises. A sticky overflow flag records the event, and software can read the current FIFO occupancy at any time.

The last pixel of a frame is only known when the next vertical sync edge arrives. For that reason, each pixel waits in a one-entry staging register until the next pixel or the next sync edge decides its end-of-packet bit.

Top module: `cvid_stream_bridge`

## Requirements
- R1: After reset, `st_valid` is 0, the status and used-words registers read 0, and the block is unsynchronised. Pixels presented before the first rising edge of `vid_vsync` are dropped.
- R2: A rising edge of `vid_vsync` starts a frame. The first pixel captured from that cycle onward leaves with `st_sop`=1, and every other pixel leaves with `st_sop`=0.
- R3: A pixel is captured only in cycles with `vid_de`=1. Captured pixels leave in arrival order with unchanged data. The last pixel of a frame carries `st_eop`=1, and it is released when the next rising edge of `vid_vsync` arrives.
- R4: While `st_valid`=1 and `st_ready`=0, the item on `st_data`/`st_sop`/`st_eop` stays unchanged on the next cycle. An item is consumed in a cycle where both are 1.
- R5: The block stores up to DEPTH pixels in the FIFO plus one pixel in the staging register, and loses no pixel while this capacity is not exceeded.
- R6: A pixel that arrives while the FIFO is full and the staging register is occupied is dropped. This is the overflow event, and the staged pixel becomes the end-of-packet of the truncated frame.
- R7: After an overflow event, every pixel is dropped until the next rising edge of `vid_vsync`. From that edge on, capture resumes with a start-of-packet.
- R8: The status register at address 0 reads the sticky overflow flag in bit 9 and the synchronised state in bit 0 (1 = capturing). All other bits read 0, and bit 0 is read-only.
- R9: A write to address 0 with bit 9 equal to 0 clears the overflow flag. A write with bit 9 equal to 1 leaves it set. Without such a clear, the flag stays at 1, and an overflow in the same cycle as a clear wins.
- R10: The register at address 1 reads the exact FIFO occupancy, from 0 to DEPTH. It changes by at most one per cycle. Addresses 2 and 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for video, stream and registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_vsync | input | 1 | Vertical sync; rising edge opens a frame |
| vid_de | input | 1 | Pixel valid in this cycle |
| vid_data | input | DATA_W | Pixel value |
| st_data | output | DATA_W | Stream pixel |
| st_sop | output | 1 | First pixel of a packet |
| st_eop | output | 1 | Last pixel of a packet |
| st_valid | output | 1 | Stream item present |
| st_ready | input | 1 | Downstream accepts the item |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data (combinational) |

## Verification
The bench builds the block with DEPTH=8 and DATA_W=8. With only nine pixels of total capacity, a single frame sent while the consumer stalls fills the FIFO to exactly DEPTH and then triggers a truncation within a few cycles. The occupancy readout can therefore be seen at both its midpoint and its upper limit. The small depth also keeps the backpressure pattern, the discard window and the later resynchronisation within a few hundred cycles.

// File: rtl/cvid_stream_bridge.sv
module cvid_stream_bridge #(
  parameter int DATA_W  = 8,
  parameter int DEPTH   = 64,
  parameter int REG_W   = 16,
  parameter int OVF_BIT = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vid_vsync,
  input  logic              vid_de,
  input  logic [DATA_W-1:0] vid_data,
  output logic [DATA_W-1:0] st_data,
  output logic              st_sop,
  output logic              st_eop,
  output logic              st_valid,
  input  logic              st_ready,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = DATA_W + 2;

  logic              vs_q, locked, sop_next, ovf_flag;
  logic              hold_vld, hold_sop, hold_eop;
  logic [DATA_W-1:0] hold_data;
  logic [EW-1:0]     mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     cnt;

  wire vs_rise = vid_vsync & ~vs_q;
  wire full    = (cnt == CW'(DEPTH));
  wire take    = vid_de & (locked | vs_rise);
  wire closing = hold_eop | vs_rise;
  wire push    = hold_vld & ~full & (closing | take);
  wire ovf_ev  = take & hold_vld & ~push;
  wire accept  = take & ~ovf_ev;
  wire pop     = st_valid & st_ready;
  wire clr     = reg_wr & (reg_addr == 2'd0) & ~reg_wdata[OVF_BIT];

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_q      <= 1'b0;
      locked    <= 1'b0;
      sop_next  <= 1'b0;
      hold_vld  <= 1'b0;
      hold_sop  <= 1'b0;
      hold_eop  <= 1'b0;
      hold_data <= '0;
    end else begin
      vs_q <= vid_vsync;
      if (ovf_ev)       locked <= 1'b0;
      else if (vs_rise) locked <= 1'b1;
      if (accept)       sop_next <= 1'b0;
      else if (vs_rise) sop_next <= 1'b1;
      if (accept) begin
        hold_vld  <= 1'b1;
        hold_sop  <= sop_next | vs_rise;
        hold_eop  <= 1'b0;
        hold_data <= vid_data;
      end else if (push) begin
        hold_vld <= 1'b0;
      end else if (hold_vld & (vs_rise | ovf_ev)) begin
        hold_eop <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= {hold_sop, closing, hold_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      cnt      <= '0;
      ovf_flag <= 1'b0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      cnt <= cnt + CW'(push) - CW'(pop);
      if (ovf_ev)   ovf_flag <= 1'b1;
      else if (clr) ovf_flag <= 1'b0;
    end
  end

  assign st_valid = (cnt != '0);
  assign {st_sop, st_eop, st_data} = mem[rd_ptr];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0: begin
        reg_rdata[OVF_BIT] = ovf_flag;
        reg_rdata[0]       = locked;
      end
      2'd1: reg_rdata[CW-1:0] = cnt;
      default: reg_rdata = '0;
    endcase
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !st_ready |=> st_valid && $stable({st_sop, st_eop, st_data})); // R4
  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R5
  AST_OVF_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev |-> full && hold_vld); // R6
  AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev |=> ovf_flag && !locked); // R7
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !clr |=> ovf_flag); // R9
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1) || (cnt + 1'b1 == $past(cnt))); // R10
endmodule

// File: tb/cvid_stream_bridge_bench.sv
`timescale 1ns/1ps
module cvid_stream_bridge_bench;
  localparam int DW = 8;
  localparam int DP = 8;
  localparam int RW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vid_vsync = 1'b0, vid_de = 1'b0;
  logic [DW-1:0] vid_data = '0;
  logic [DW-1:0] st_data;
  logic st_sop, st_eop, st_valid;
  logic st_ready = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic reg_wr = 1'b0;
  logic [RW-1:0] reg_wdata = '0;
  logic [RW-1:0] reg_rdata;

  int total = 0, bad = 0, ready_mode = 1, cyc = 0;
  bit done = 0;
  logic [DW+1:0] exp_q [$];

  always #10 clk = ~clk;

  cvid_stream_bridge #(.DATA_W(DW), .DEPTH(DP), .REG_W(RW), .OVF_BIT(9)) u_cvid_stream_bridge (
    .clk(clk), .rst_n(rst_n), .vid_vsync(vid_vsync), .vid_de(vid_de), .vid_data(vid_data),
    .st_data(st_data), .st_sop(st_sop), .st_eop(st_eop), .st_valid(st_valid), .st_ready(st_ready),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial forever begin
    @(posedge clk); #1;
    cyc++;
    case (ready_mode)
      0: st_ready = 1'b0;
      1: st_ready = 1'b1;
      default: st_ready = (cyc % 4) != 3;
    endcase
  end

  logic [DW+1:0] last_item;
  bit was_stall = 0;
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (was_stall) begin
        check("R4 stall valid", {31'd0, st_valid}, 32'd1);
        check("R4 stall item", {22'd0, st_sop, st_eop, st_data}, {22'd0, last_item});
      end
      was_stall = st_valid && !st_ready;
      last_item = {st_sop, st_eop, st_data};
      if (st_valid && st_ready) begin
        if (exp_q.size() == 0) begin
          total++; bad++;
          $display("FAIL R3 unexpected item actual=%0h expected=none", last_item);
        end else begin
          check("R2 R3 stream item", {22'd0, last_item}, {22'd0, exp_q.pop_front()});
        end
      end
    end
  end

  task automatic vsync_pulse();
    @(posedge clk); #1 vid_vsync = 1'b1;
    @(posedge clk); #1 vid_vsync = 1'b0;
  endtask

  task automatic pixels(input int n, input int base, input int keep);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 vid_de = 1'b1; vid_data = DW'(base + i);
      if (i < keep) exp_q.push_back({i == 0, i == keep - 1, DW'(base + i)});
    end
    @(posedge clk); #1 vid_de = 1'b0;
  endtask

  task automatic raw_pixels(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 vid_de = 1'b1; vid_data = DW'(8'hE0 + i);
    end
    @(posedge clk); #1 vid_de = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [RW-1:0] v);
    @(posedge clk); #1 reg_addr = a;
    @(negedge clk); v = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [RW-1:0] d);
    @(posedge clk); #1 reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  initial begin
    logic [RW-1:0] v;
    int used_c;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset valid", {31'd0, st_valid}, 32'd0);
    rst_n = 1'b1;
    rd(2'd0, v); check("R1 reset status", {16'd0, v}, 32'd0);
    rd(2'd1, v); check("R1 reset used", {16'd0, v}, 32'd0);
    rd(2'd2, v); check("R10 unused address", {16'd0, v}, 32'd0);

    raw_pixels(3); idle(4);
    rd(2'd1, v); check("R1 pre-sync pixels dropped", {16'd0, v}, 32'd0);

    vsync_pulse(); pixels(6, 8'h10, 6); idle(4);
    rd(2'd0, v); check("R8 locked bit", {16'd0, v}, 32'h1);
    ready_mode = 2;
    vsync_pulse(); pixels(12, 8'h40, 12); idle(4);
    ready_mode = 1;
    vsync_pulse(); idle(10);
    rd(2'd1, v); check("R10 drained used", {16'd0, v}, 32'd0);

    ready_mode = 0;
    pixels(5, 8'h80, 5);
    vsync_pulse(); idle(2);
    rd(2'd1, v); check("R5 R10 used words mid", {16'd0, v}, 32'd5);
    used_c = 5;
    pixels(10, 8'hA0, DP - used_c + 1); idle(2);
    rd(2'd1, v); check("R10 used words at depth", {16'd0, v}, DP);
    rd(2'd0, v); check("R6 R8 overflow flagged, unlocked", {16'd0, v}, 32'h200);
    raw_pixels(3); idle(2);
    rd(2'd1, v); check("R7 discard keeps level", {16'd0, v}, DP);
    wr(2'd0, 16'h0201);
    rd(2'd0, v); check("R9 write one keeps flag, R8 bit0 read-only", {16'd0, v}, 32'h200);
    ready_mode = 1; idle(25);
    rd(2'd1, v); check("R10 empty after drain", {16'd0, v}, 32'd0);
    rd(2'd0, v); check("R9 flag sticky after drain", {16'd0, v}, 32'h200);
    wr(2'd0, 16'h0000);
    rd(2'd0, v); check("R9 flag cleared", {16'd0, v}, 32'd0);

    vsync_pulse(); pixels(4, 8'hC0, 4);
    vsync_pulse(); idle(10);
    rd(2'd0, v); check("R7 resynchronised", {16'd0, v}, 32'h1);
    check("R3 all items delivered", exp_q.size(), 32'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule